// File: doc/BRIEF.md
# Memory-Mapped GPIO Port Controller

This block controls one bank of general-purpose pins. A host writes an output data register and a direction register over a simple request bus, and reads back a synchronised copy of the pin levels. Three write-only alias addresses change chosen bits of the output data without a read-modify-write sequence. One writes ones into the selected bits, one writes zeros into them, and one inverts them. The block drives a value and an output enable for each pin.

The pin inputs pass through a two-flop synchroniser and are then captured into an input register. Capture happens only while an external port enable is high. Pins whose external digital-mode bit is low are captured as zero.

The request side has no back-pressure. A request presented with `req_valid` high is taken on that clock edge. Exactly one cycle later `rsp_valid` is high, and `rsp_rdata` carries the read value, or zero for a write. The initiator may issue a request on every cycle.

Top module: `pin_bank_ctrl`

## Requirements
- R1: After reset, pin_out, pin_oe, rsp_valid and rsp_rdata are zero. Reads of byte offsets 0x00, 0x10 and 0x14 return zero until they are written or the pins change.
- R2: A request taken at a clock edge gives rsp_valid high after that edge for one cycle. A read of offset 0x00 returns the output data register, and a read of offset 0x14 returns the direction register. A full-word write to either offset replaces that register.
- R3: A write to offset 0x04 sets to 1 every output data bit whose write-data bit is 1 and leaves the other bits unchanged.
- R4: A write to offset 0x08 clears to 0 every output data bit whose write-data bit is 1 and leaves the other bits unchanged.
- R5: A write to offset 0x0C inverts every output data bit whose write-data bit is 1 and leaves the other bits unchanged.
- R6: Reads of offsets 0x04, 0x08 and 0x0C return zero. Alias writes do not change the direction register.
- R7: pin_oe equals the direction register (1 = output). pin_out carries the output data bit where the direction bit is 1 and is 0 elsewhere.
- R8: A pin level that is steady before clock edge k shows in a read of offset 0x10 issued at edge k+3 or later. The bit reads 1 only if that pin's dig_en bit is 1.
- R9: While port_en is low, the input register holds its value whatever pin_in and dig_en do.
- R10: Writes to offset 0x10, to an unmapped offset or to a misaligned offset change no register. Reads of unmapped or misaligned offsets return zero.
- R11: An alias write is followed on the very next cycle by a read of offset 0x00 that already shows the updated value. Back-to-back alias writes on consecutive cycles each apply to the result of the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Byte offset of the register |
| req_wdata | input | PINS | Write data |
| rsp_valid | output | 1 | Response for the request of the previous cycle |
| rsp_rdata | output | PINS | Read data (zero for writes) |
| pin_in | input | PINS | Asynchronous pin levels |
| dig_en | input | PINS | Per-pin digital-mode enable |
| port_en | input | 1 | Port module enable; low freezes input capture |
| pin_out | output | PINS | Driven pin values |
| pin_oe | output | PINS | Per-pin output enable |

## Verification
The bench runs a behavioural model in parallel with the block and compares against it on every clock. A corrupted output data or direction bit shows on pin_out or pin_oe one cycle after the faulty write. A wrong alias mask shows on the same pins at that same point. A fault on the input path, such as a wrong synchroniser depth, a missing digital-mode mask or capture while disabled, stays hidden until the next read of offset 0x10. That read differs from the model three cycles after a pin change.

// File: rtl/gpb_pkg.sv
package gpb_pkg;
  typedef enum logic [2:0] {
    SEL_DOUT,
    SEL_SET,
    SEL_CLR,
    SEL_TOG,
    SEL_DIN,
    SEL_DIR,
    SEL_NONE
  } gpb_sel_e;

  localparam int unsigned OFS_DOUT = 'h00;
  localparam int unsigned OFS_SET  = 'h04;
  localparam int unsigned OFS_CLR  = 'h08;
  localparam int unsigned OFS_TOG  = 'h0C;
  localparam int unsigned OFS_DIN  = 'h10;
  localparam int unsigned OFS_DIR  = 'h14;
endpackage

// File: rtl/gpb_decode.sv
module gpb_decode #(
  parameter int AW = 8
) (
  input  logic [AW-1:0]      addr,
  output gpb_pkg::gpb_sel_e  sel
);
  import gpb_pkg::*;

  always_comb begin
    if      (addr == AW'(OFS_DOUT)) sel = SEL_DOUT;
    else if (addr == AW'(OFS_SET))  sel = SEL_SET;
    else if (addr == AW'(OFS_CLR))  sel = SEL_CLR;
    else if (addr == AW'(OFS_TOG))  sel = SEL_TOG;
    else if (addr == AW'(OFS_DIN))  sel = SEL_DIN;
    else if (addr == AW'(OFS_DIR))  sel = SEL_DIR;
    else                            sel = SEL_NONE;
  end
endmodule

// File: rtl/gpb_out_regs.sv
module gpb_out_regs #(
  parameter int PINS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  gpb_pkg::gpb_sel_e sel,
  input  logic [PINS-1:0]   wdata,
  output logic [PINS-1:0]   dout_q,
  output logic [PINS-1:0]   dir_q
);
  import gpb_pkg::*;

  logic [PINS-1:0] dout_d;

  // per-bit next value: each alias acts only where its mask bit is 1
  for (genvar b = 0; b < PINS; b++) begin : g_bit
    always_comb begin
      dout_d[b] = dout_q[b];
      if (wr_en) begin
        unique case (sel)
          SEL_DOUT: dout_d[b] = wdata[b];
          SEL_SET:  if (wdata[b]) dout_d[b] = 1'b1;
          SEL_CLR:  if (wdata[b]) dout_d[b] = 1'b0;
          SEL_TOG:  if (wdata[b]) dout_d[b] = ~dout_q[b];
          default:  dout_d[b] = dout_q[b];
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= '0;
      dir_q  <= '0;
    end else begin
      dout_q <= dout_d;
      if (wr_en && sel == SEL_DIR) dir_q <= wdata;
    end
  end
endmodule

// File: rtl/gpb_in_sync.sv
module gpb_in_sync #(
  parameter int PINS   = 32,
  parameter int STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PINS-1:0] pin_in,
  input  logic [PINS-1:0] dig_en,
  input  logic            port_en,
  output logic [PINS-1:0] din_q
);
  logic [STAGES-1:0][PINS-1:0] sync_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sync_q[s] <= '0;
      else if (s == 0) sync_q[s] <= pin_in;
      else             sync_q[s] <= sync_q[(s == 0) ? 0 : s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       din_q <= '0;
    else if (port_en) din_q <= sync_q[STAGES-1] & dig_en;
  end
endmodule

// File: rtl/pin_bank_ctrl.sv
module pin_bank_ctrl #(
  parameter int PINS = 32,
  parameter int AW   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic            req_write,
  input  logic [AW-1:0]   req_addr,
  input  logic [PINS-1:0] req_wdata,
  output logic            rsp_valid,
  output logic [PINS-1:0] rsp_rdata,
  input  logic [PINS-1:0] pin_in,
  input  logic [PINS-1:0] dig_en,
  input  logic            port_en,
  output logic [PINS-1:0] pin_out,
  output logic [PINS-1:0] pin_oe
);
  import gpb_pkg::*;

  localparam int SYNC_STAGES = 2;

  gpb_sel_e        sel;
  logic [PINS-1:0] dout_q;
  logic [PINS-1:0] dir_q;
  logic [PINS-1:0] din_q;
  logic [PINS-1:0] rd_mux;
  logic            wr_en;

  assign wr_en = req_valid & req_write;

  gpb_decode #(.AW(AW)) u_dec (
    .addr (req_addr),
    .sel  (sel)
  );

  gpb_out_regs #(.PINS(PINS)) u_out (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .sel    (sel),
    .wdata  (req_wdata),
    .dout_q (dout_q),
    .dir_q  (dir_q)
  );

  gpb_in_sync #(.PINS(PINS), .STAGES(SYNC_STAGES)) u_in (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin_in  (pin_in),
    .dig_en  (dig_en),
    .port_en (port_en),
    .din_q   (din_q)
  );

  always_comb begin
    unique case (sel)
      SEL_DOUT: rd_mux = dout_q;
      SEL_DIN:  rd_mux = din_q;
      SEL_DIR:  rd_mux = dir_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_rdata <= (req_valid && !req_write) ? rd_mux : '0;
    end
  end

  assign pin_oe  = dir_q;
  assign pin_out = dout_q & dir_q;
endmodule

// File: rtl/gpb_chk.sv
module gpb_chk #(
  parameter int PINS = 32,
  parameter int AW   = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_write,
  input logic [AW-1:0]   req_addr,
  input logic [PINS-1:0] req_wdata,
  input logic            rsp_valid,
  input logic [PINS-1:0] rsp_rdata,
  input logic            port_en,
  input logic [PINS-1:0] pin_out,
  input logic [PINS-1:0] pin_oe,
  input logic [PINS-1:0] dout_q,
  input logic [PINS-1:0] dir_q,
  input logic [PINS-1:0] din_q
);
  import gpb_pkg::*;

  logic wr, rd;
  assign wr = req_valid & req_write;
  assign rd = req_valid & ~req_write;

  AST_RSP_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R2

  AST_SET_BITS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && req_addr == AW'(OFS_SET)) |=> ((dout_q & $past(req_wdata)) == $past(req_wdata))); // R3

  AST_CLR_BITS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && req_addr == AW'(OFS_CLR)) |=> ((dout_q & $past(req_wdata)) == '0)); // R4

  AST_TOG_BITS_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && req_addr == AW'(OFS_TOG)) |=> (dout_q == ($past(dout_q) ^ $past(req_wdata)))); // R5

  AST_ALIAS_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && (req_addr == AW'(OFS_SET) || req_addr == AW'(OFS_CLR) || req_addr == AW'(OFS_TOG)))
    |=> (rsp_rdata == '0)); // R6

  AST_NO_DRIVE_INPUT_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_out & ~pin_oe) == '0); // R7

  AST_FROZEN_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |=> $stable(din_q)); // R9

  AST_DIN_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && req_addr == AW'(OFS_DIN)) |=> ($stable(dout_q) && $stable(dir_q))); // R10
endmodule

bind pin_bank_ctrl gpb_chk #(.PINS(PINS), .AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_addr  (req_addr),
  .req_wdata (req_wdata),
  .rsp_valid (rsp_valid),
  .rsp_rdata (rsp_rdata),
  .port_en   (port_en),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe),
  .dout_q    (dout_q),
  .dir_q     (dir_q),
  .din_q     (din_q)
);

// File: tb/pin_bank_ctrl_tb.sv
module pin_bank_ctrl_tb;
  localparam int PINS = 32;
  localparam int AW   = 8;

  logic            clk = 0;
  logic            rst_n = 0;
  logic            req_valid = 0, req_write = 0;
  logic [AW-1:0]   req_addr = '0;
  logic [PINS-1:0] req_wdata = '0;
  logic            rsp_valid;
  logic [PINS-1:0] rsp_rdata;
  logic [PINS-1:0] pin_in = '0, dig_en = '0;
  logic            port_en = 0;
  logic [PINS-1:0] pin_out, pin_oe;

  int checks = 0, fails = 0;

  always #10 clk = ~clk; // 50 MHz

  pin_bank_ctrl #(.PINS(PINS), .AW(AW)) u_dut (.*);

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_dout, m_dir, m_din, m_rdata;
  logic        m_rvalid;
  logic [31:0] m_pipe[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_dout = 0; m_dir = 0; m_din = 0; m_rdata = 0; m_rvalid = 0;
      m_pipe = {32'h0, 32'h0};
    end else begin
      logic [31:0] rv;
      logic [31:0] oldest;
      rv = 0;
      if (req_valid && !req_write) begin
        if (req_addr == 8'h00) rv = m_dout;
        else if (req_addr == 8'h10) rv = m_din;
        else if (req_addr == 8'h14) rv = m_dir;
      end
      m_rvalid = req_valid;
      m_rdata  = rv;
      if (req_valid && req_write) begin
        case (req_addr)
          8'h00: m_dout = req_wdata;
          8'h04: m_dout = m_dout | req_wdata;
          8'h08: m_dout = m_dout & ~req_wdata;
          8'h0C: m_dout = m_dout ^ req_wdata;
          8'h14: m_dir  = req_wdata;
          default: ;
        endcase
      end
      m_pipe.push_back(pin_in);
      oldest = m_pipe.pop_front();
      if (port_en) m_din = oldest & dig_en;
    end
  end

  // per-clock comparison, sampled away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (pin_oe !== m_dir) begin
        fails++; $display("FAIL R7 pin_oe act=%h exp=%h", pin_oe, m_dir);
      end
      checks++;
      if (pin_out !== (m_dout & m_dir)) begin
        fails++; $display("FAIL R7 pin_out act=%h exp=%h", pin_out, m_dout & m_dir);
      end
      checks++;
      if (rsp_valid !== m_rvalid || rsp_rdata !== m_rdata) begin
        fails++;
        $display("FAIL R2 rsp act=%b/%h exp=%b/%h", rsp_valid, rsp_rdata, m_rvalid, m_rdata);
      end
    end
  end

  // ---------------- directed helpers ----------------
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
    req_valid = 1; req_write = 0; req_addr = a; req_wdata = '0;
    @(negedge clk);
    req_valid = 0;
    checks++;
    if (rsp_valid !== 1'b1 || rsp_rdata !== exp) begin
      fails++;
      $display("FAIL %s read %h act=%h exp=%h", tag, a, rsp_rdata, exp);
    end
  endtask

  task automatic pin_chk(input logic [31:0] exp, input string tag);
    checks++;
    if (pin_out !== exp) begin
      fails++; $display("FAIL %s pin_out act=%h exp=%h", tag, pin_out, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic run_main;
    rst_n = 0;
    idle(3);
    rst_n = 1;
    idle(1);
    // R1: reset state
    checks++;
    if (pin_out !== 0 || pin_oe !== 0 || rsp_valid !== 0 || rsp_rdata !== 0) begin
      fails++; $display("FAIL R1 outputs act=%h/%h exp=0", pin_out, pin_oe);
    end
    rd_chk(8'h00, 32'h0, "R1");
    rd_chk(8'h14, 32'h0, "R1");
    rd_chk(8'h10, 32'h0, "R1");
    // R2: plain register writes
    wr(8'h00, 32'hA5A5_0F0F);
    wr(8'h14, 32'hFFFF_0000);
    rd_chk(8'h00, 32'hA5A5_0F0F, "R2");
    rd_chk(8'h14, 32'hFFFF_0000, "R2");
    pin_chk(32'hA5A5_0000, "R7");
    // R3 / R4 / R5 aliases
    wr(8'h04, 32'h0000_00F0);
    rd_chk(8'h00, 32'hA5A5_0FFF, "R3");
    wr(8'h08, 32'hA500_0000);
    rd_chk(8'h00, 32'h00A5_0FFF, "R4");
    wr(8'h0C, 32'hFFFF_0000);
    rd_chk(8'h00, 32'hFF5A_0FFF, "R5");
    pin_chk(32'hFF5A_0000, "R5");
    // R6: aliases read zero, direction untouched
    rd_chk(8'h04, 32'h0, "R6");
    rd_chk(8'h08, 32'h0, "R6");
    rd_chk(8'h0C, 32'h0, "R6");
    rd_chk(8'h14, 32'hFFFF_0000, "R6");
    // R11: back-to-back aliases
    wr(8'h08, 32'hFFFF_FFFF);
    wr(8'h04, 32'h0001_0001);
    wr(8'h0C, 32'h0003_0003);
    rd_chk(8'h00, 32'h0002_0002, "R11");
    // R8: input path
    dig_en = 32'hFFFF_FFFF; port_en = 1; pin_in = 32'h1234_5678;
    idle(3);
    rd_chk(8'h10, 32'h1234_5678, "R8");
    dig_en = 32'h0000_FFFF;
    idle(1);
    rd_chk(8'h10, 32'h0000_5678, "R8");
    // R9: freeze while disabled
    port_en = 0; pin_in = 32'hFFFF_FFFF; dig_en = 32'hFFFF_FFFF;
    idle(5);
    rd_chk(8'h10, 32'h0000_5678, "R9");
    port_en = 1;
    idle(3);
    rd_chk(8'h10, 32'hFFFF_FFFF, "R9");
    // R10: ignored writes and zero reads
    wr(8'h10, 32'h0);
    wr(8'h18, 32'hFFFF_FFFF);
    wr(8'h02, 32'hFFFF_FFFF);
    rd_chk(8'h00, 32'h0002_0002, "R10");
    rd_chk(8'h14, 32'hFFFF_0000, "R10");
    rd_chk(8'h18, 32'h0, "R10");
    rd_chk(8'h15, 32'h0, "R10");
    // mixed traffic, compared every clock against the model
    for (int i = 0; i < 400; i++) begin
      logic [2:0] pick;
      pick = 3'($urandom_range(0, 7));
      req_valid = ($urandom_range(0, 3) != 0);
      req_write = $urandom_range(0, 1);
      req_addr  = (pick == 7) ? 8'h1C : {3'b0, pick, 2'b00};
      req_wdata = $urandom;
      pin_in    = $urandom;
      if ($urandom_range(0, 7) == 0) dig_en = $urandom;
      if ($urandom_range(0, 9) == 0) port_en = ~port_en;
      @(negedge clk);
    end
    req_valid = 0;
    idle(2);
  endtask

  initial begin
    fork
      run_main();
      begin
        idle(20000);
        fails++;
        $display("FAIL watchdog expired act=timeout exp=done");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule